// File: doc/BRIEF.md
# Infrared Run-Length Transmitter

This block drives a consumer-infrared emitter from a stream of run-length bytes written by a host. Each byte is placed in a 32-entry queue. Bit 7 of a byte picks the run type: clear means a mark (carrier on) and set means a gap (line low). Bits 6:0 give the run length in base sample periods. The base sample period is `sample_div + 1` clock cycles. The engine takes bytes one after another with no idle cycle between them. During a mark it gates a carrier made by a programmable divider and duty count. When the queue runs dry it returns the line to idle low.

The host can read the queue occupancy and empty the queue with one strobe. It can also redirect the waveform to an internal loopback output. A level-sensitive low-data interrupt tells the host when to refill. It is merged with two receive-side event inputs into a pending flag with a 2-bit cause code.

Top module: `irtx_engine`

## Requirements
- R1: The queue holds 32 bytes in arrival order. `fill_count` gives the exact occupancy from 0 to 32, and a write made while the queue is full is dropped.
- R2: Raising `fifo_clear` for one cycle makes `fill_count` read 0 after the next clock edge. The clear wins over a write made in the same cycle.
- R3: A byte is taken one clock edge after `tx_enable` is high with the queue non-empty and the engine free. Its run starts in the following cycle and lasts `len * (sample_div + 1)` cycles. Bit 7 = 0 is a mark and bit 7 = 1 is a gap, during which `ir_out` is 0.
- R4: A length field of 0 means a run of 128 sample periods.
- R5: When a run ends and another byte is waiting, the next run starts in the very next cycle. When no byte is waiting, `ir_out` stays 0.
- R6: In the k-th cycle of a mark run (k = 0 at run start), `ir_out` is 1 exactly when `k mod (carrier_div + 1) < carrier_duty`.
- R7: `thr_sel` codes 0, 1, 2 and 3 select levels 1, 7, 17 and 25. The transmit-low condition holds while `tx_enable` is 1 and `fill_count` is at or below the selected level.
- R8: `irq` is 1 only when `ie_global` is 1 and at least one enabled source is active. The sources are transmit-low (`ie_txlow`), `rx_data_evt` (`ie_rxdata`) and `rx_ovr_evt` (`ie_rxovr`). `irq_cause` is 11 for overrun, 10 for receive data and 01 for transmit-low, with priority in that order, and 00 when `irq` is 0.
- R9: While `loop_en` is 1, the waveform appears on `loop_out` and `ir_out` is held at 0. While `loop_en` is 0, `loop_out` is 0.
- R10: While `tx_enable` is 0, no new byte is taken from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 8 | Run byte: bit 7 gap flag, bits 6:0 length |
| fifo_clear | input | 1 | Empty the queue |
| tx_enable | input | 1 | Allow bytes to be taken |
| thr_sel | input | 2 | Low-data level select |
| sample_div | input | SDW | Base sample period minus one, in clocks |
| carrier_div | input | CDW | Carrier period minus one, in clocks |
| carrier_duty | input | CDW | Carrier high cycles per period |
| loop_en | input | 1 | Route waveform to `loop_out` |
| ie_global | input | 1 | Global interrupt enable |
| ie_txlow | input | 1 | Transmit-low enable |
| ie_rxdata | input | 1 | Receive-data enable |
| ie_rxovr | input | 1 | Receive-overrun enable |
| rx_data_evt | input | 1 | Receive-data event level |
| rx_ovr_evt | input | 1 | Receive-overrun event level |
| ir_out | output | 1 | Emitter drive |
| loop_out | output | 1 | Loopback waveform |
| fill_count | output | 6 | Queue occupancy |
| irq | output | 1 | Interrupt pending |
| irq_cause | output | 2 | Interrupt cause code |

## Verification
The properties take for granted that the host holds `sample_div`, `carrier_div` and `carrier_duty` steady while a run is in progress. They also assume that all inputs change only between clock edges, so an input sampled at an edge is the value that edge acts on. The stimulus changes these inputs only on the falling clock edge. It reprograms the timing fields only while `tx_enable` is low and the engine is idle. Waveforms are compared cycle by cycle against sequences the bench builds from the byte list. The interrupt merge is swept over every combination of enables and event inputs.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_TXLOW  = 2'b01,
    CAUSE_RXDATA = 2'b10,
    CAUSE_RXOVR  = 2'b11
  } irq_cause_e;

  // Low-data level picked by the 2-bit threshold code.
  function automatic logic [5:0] thr_level(input logic [1:0] sel);
    case (sel)
      2'd0:    thr_level = 6'd1;
      2'd1:    thr_level = 6'd7;
      2'd2:    thr_level = 6'd17;
      default: thr_level = 6'd25;
    endcase
  endfunction

  // A zero length field stands for the longest run.
  function automatic logic [7:0] run_len(input logic [6:0] field);
    run_len = (field == 7'd0) ? 8'd128 : {1'b0, field};
  endfunction

endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push_req,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push;

  assign push  = push_req && (cnt_q != CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign rdata = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clear) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = wptr_q + AW'(1);
      if (pop)  rptr_d = rptr_q + AW'(1);
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wptr_q] <= wdata;
  end

endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
  parameter int CDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart,
  input  logic           run,
  input  logic [CDW-1:0] div,
  input  logic [CDW-1:0] duty,
  output logic           carrier
);

  logic [CDW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (run)    cnt_d = (cnt_q == div) ? '0 : cnt_q + CDW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign carrier = (cnt_q < duty);

endmodule

// File: rtl/irtx_runner.sv
module irtx_runner
  import irtx_pkg::*;
#(
  parameter int SDW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tx_enable,
  input  logic           fifo_empty,
  input  logic [7:0]     fifo_data,
  input  logic [SDW-1:0] sample_div,
  output logic           load,
  output logic           active,
  output logic           space
);

  logic           act_q, act_d;
  logic           spc_q, spc_d;
  logic [7:0]     rem_q, rem_d;
  logic [SDW-1:0] pcnt_q, pcnt_d;
  logic           tick, run_end;

  assign tick    = act_q && (pcnt_q == sample_div);
  assign run_end = tick && (rem_q == 8'd1);
  assign load    = tx_enable && !fifo_empty && (!act_q || run_end);

  always_comb begin
    act_d  = act_q;
    spc_d  = spc_q;
    rem_d  = rem_q;
    pcnt_d = pcnt_q;
    if (load) begin
      act_d  = 1'b1;
      spc_d  = fifo_data[7];
      rem_d  = run_len(fifo_data[6:0]);
      pcnt_d = '0;
    end else if (run_end) begin
      act_d  = 1'b0;
      pcnt_d = '0;
    end else if (tick) begin
      pcnt_d = '0;
      rem_d  = rem_q - 8'd1;
    end else if (act_q) begin
      pcnt_d = pcnt_q + SDW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      spc_q  <= 1'b0;
      rem_q  <= '0;
      pcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      spc_q  <= spc_d;
      rem_q  <= rem_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign active = act_q;
  assign space  = spc_q;

endmodule

// File: rtl/irtx_engine.sv
module irtx_engine
  import irtx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SDW   = 8,
  parameter int CDW   = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [7:0]     wr_data,
  input  logic           fifo_clear,
  input  logic           tx_enable,
  input  logic [1:0]     thr_sel,
  input  logic [SDW-1:0] sample_div,
  input  logic [CDW-1:0] carrier_div,
  input  logic [CDW-1:0] carrier_duty,
  input  logic           loop_en,
  input  logic           ie_global,
  input  logic           ie_txlow,
  input  logic           ie_rxdata,
  input  logic           ie_rxovr,
  input  logic           rx_data_evt,
  input  logic           rx_ovr_evt,
  output logic           ir_out,
  output logic           loop_out,
  output logic [CW-1:0]  fill_count,
  output logic           irq,
  output logic [1:0]     irq_cause
);

  logic [7:0] head;
  logic       empty, load, active, space, carrier, wave;
  logic       tx_low, src_low, src_rxd, src_ovr;

  irtx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear), .push_req(wr_en),
    .pop(load), .wdata(wr_data), .rdata(head), .count(fill_count),
    .empty(empty)
  );

  irtx_runner #(.SDW(SDW)) u_runner (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .fifo_empty(empty),
    .fifo_data(head), .sample_div(sample_div), .load(load),
    .active(active), .space(space)
  );

  irtx_carrier #(.CDW(CDW)) u_carrier (
    .clk(clk), .rst_n(rst_n), .restart(load), .run(active),
    .div(carrier_div), .duty(carrier_duty), .carrier(carrier)
  );

  assign wave     = active && !space && carrier;
  assign ir_out   = wave && !loop_en;
  assign loop_out = wave && loop_en;

  assign tx_low  = tx_enable && (fill_count <= CW'(thr_level(thr_sel)));
  assign src_low = ie_global && ie_txlow  && tx_low;
  assign src_rxd = ie_global && ie_rxdata && rx_data_evt;
  assign src_ovr = ie_global && ie_rxovr  && rx_ovr_evt;

  always_comb begin
    if (src_ovr)      irq_cause = CAUSE_RXOVR;
    else if (src_rxd) irq_cause = CAUSE_RXDATA;
    else if (src_low) irq_cause = CAUSE_TXLOW;
    else              irq_cause = CAUSE_NONE;
  end

  assign irq = src_ovr || src_rxd || src_low;

endmodule

// File: rtl/irtx_engine_checker.sv
module irtx_engine_checker #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clear,
  input logic          tx_enable,
  input logic          loop_en,
  input logic          ie_global,
  input logic          ie_txlow,
  input logic [CW-1:0] fill_count,
  input logic          ir_out,
  input logic          loop_out,
  input logic          irq,
  input logic [1:0]    irq_cause
);

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> (fill_count == '0));

  assert_low_level_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_global && ie_txlow && tx_enable && fill_count <= CW'(1)) |-> irq);

  assert_global_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_global |-> (!irq && irq_cause == 2'b00));

  assert_cause_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_cause != 2'b00));

  assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> !ir_out);

  assert_loop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> !loop_out);

  assert_no_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enable && !fifo_clear) |=> (fill_count >= $past(fill_count)));

endmodule

bind irtx_engine irtx_engine_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clear(fifo_clear), .tx_enable(tx_enable),
  .loop_en(loop_en), .ie_global(ie_global), .ie_txlow(ie_txlow),
  .fill_count(fill_count), .ir_out(ir_out), .loop_out(loop_out),
  .irq(irq), .irq_cause(irq_cause)
);

// File: tb/irtx_engine_bench.sv
module irtx_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, fifo_clear, tx_enable, loop_en;
  logic [7:0] wr_data;
  logic [1:0] thr_sel;
  logic [7:0] sample_div, carrier_div, carrier_duty;
  logic       ie_global, ie_txlow, ie_rxdata, ie_rxovr, rx_data_evt, rx_ovr_evt;
  logic       ir_out, loop_out, irq;
  logic [5:0] fill_count;
  logic [1:0] irq_cause;

  int checks = 0;
  int failures = 0;
  int hi_cnt = 0;
  logic [7:0] bytes_q [0:39];

  always #10 clk = ~clk;

  irtx_engine u_irtx_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_clear(fifo_clear), .tx_enable(tx_enable), .thr_sel(thr_sel),
    .sample_div(sample_div), .carrier_div(carrier_div),
    .carrier_duty(carrier_duty), .loop_en(loop_en), .ie_global(ie_global),
    .ie_txlow(ie_txlow), .ie_rxdata(ie_rxdata), .ie_rxovr(ie_rxovr),
    .rx_data_evt(rx_data_evt), .rx_ovr_evt(rx_ovr_evt), .ir_out(ir_out),
    .loop_out(loop_out), .fill_count(fill_count), .irq(irq),
    .irq_cause(irq_cause)
  );

  always @(negedge clk) if (ir_out) hi_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int level_of(input int sel);
    case (sel)
      0: return 1;
      1: return 7;
      2: return 17;
      default: return 25;
    endcase
  endfunction

  task automatic clear_q();
    @(negedge clk) fifo_clear = 1'b1;
    @(negedge clk) fifo_clear = 1'b0;
  endtask

  task automatic load_bytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = bytes_q[i];
    end
    @(negedge clk) wr_en = 1'b0;
  endtask

  // Play n queued bytes and compare the chosen output cycle by cycle.
  task automatic play(input int n, input bit loopm, input string tag);
    int mism = 0;
    int p = int'(sample_div) + 1;
    @(negedge clk) tx_enable = 1'b1;
    for (int j = 0; j < n; j++) begin
      int len = (bytes_q[j][6:0] == 7'd0) ? 128 : int'(bytes_q[j][6:0]);
      for (int t = 0; t < len * p; t++) begin
        bit e = bytes_q[j][7] ? 1'b0 : ((t % (int'(carrier_div) + 1)) < int'(carrier_duty));
        @(negedge clk);
        if ((loopm ? loop_out : ir_out) !== e) mism++;
        if (loopm && ir_out !== 1'b0) mism++;
      end
    end
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      if (ir_out !== 1'b0 || loop_out !== 1'b0) mism++;
    end
    tx_enable = 1'b0;
    chk(mism == 0, tag, mism, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = 0; fifo_clear = 0; tx_enable = 0;
    loop_en = 0; thr_sel = 2; sample_div = 0; carrier_div = 1; carrier_duty = 2;
    ie_global = 0; ie_txlow = 0; ie_rxdata = 0; ie_rxovr = 0;
    rx_data_evt = 0; rx_ovr_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fill_count == 0, "reset fill R1", fill_count, 0);
    chk(ir_out == 0 && loop_out == 0, "reset outputs R5", ir_out, 0);
    chk(irq == 0 && irq_cause == 0, "reset irq R8", irq, 0);

    // R1: fill sweep past capacity, then order check
    for (int i = 0; i < 35; i++)
      bytes_q[i] = {((i % 2) == 1) ? 1'b1 : 1'b0, 7'(i + 1)};
    for (int i = 0; i < 35; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = bytes_q[i];
      @(negedge clk); wr_en = 1'b0;
      chk(fill_count == ((i + 1 > 32) ? 32 : i + 1), "count R1", fill_count,
          (i + 1 > 32) ? 32 : i + 1);
    end
    play(32, 1'b0, "order and drop R1 R3");
    chk(fill_count == 0, "drained R5", fill_count, 0);

    // R3 R5 R6: mixed runs with a gated carrier
    sample_div = 2; carrier_div = 3; carrier_duty = 2;
    bytes_q[0] = 8'h03; bytes_q[1] = 8'h82; bytes_q[2] = 8'h01;
    bytes_q[3] = 8'h85; bytes_q[4] = 8'h02;
    load_bytes(5);
    play(5, 1'b0, "mark gap carrier R3 R5 R6");

    // R4: zero-length fields become 128 periods
    sample_div = 0; carrier_div = 4; carrier_duty = 1;
    bytes_q[0] = 8'h00; bytes_q[1] = 8'h80; bytes_q[2] = 8'h01;
    load_bytes(3);
    play(3, 1'b0, "zero length R4 R6");

    // R9: loopback
    loop_en = 1'b1; sample_div = 1; carrier_div = 2; carrier_duty = 1;
    bytes_q[0] = 8'h04; bytes_q[1] = 8'h83; bytes_q[2] = 8'h02;
    load_bytes(3);
    play(3, 1'b1, "loopback R9");
    loop_en = 1'b0;

    // R10: disabled transmitter leaves the queue untouched
    bytes_q[0] = 8'h05; bytes_q[1] = 8'h06; bytes_q[2] = 8'h07;
    load_bytes(3);
    begin
      int hi = 0;
      for (int t = 0; t < 50; t++) begin @(negedge clk); if (ir_out) hi++; end
      chk(hi == 0, "idle output R10", hi, 0);
    end
    chk(fill_count == 3, "no take R10", fill_count, 3);

    // R2: clear beats a same-cycle write
    @(negedge clk); fifo_clear = 1'b1; wr_en = 1'b1; wr_data = 8'h11;
    @(negedge clk); fifo_clear = 1'b0; wr_en = 1'b0;
    chk(fill_count == 0, "clear R2", fill_count, 0);
    @(negedge clk) tx_enable = 1'b1;
    repeat (4) @(negedge clk);
    chk(ir_out == 0, "empty after clear R2", ir_out, 0);
    tx_enable = 1'b0;

    // R8: exhaustive interrupt merge with an empty queue
    begin
      int bad = 0;
      for (int c = 0; c < 128; c++) begin
        int ecause;
        bit lo, rd, ov;
        @(negedge clk);
        tx_enable = c[0]; ie_global = c[1]; ie_txlow = c[2]; ie_rxdata = c[3];
        ie_rxovr = c[4]; rx_data_evt = c[5]; rx_ovr_evt = c[6];
        #5;
        lo = c[1] && c[2] && c[0];
        rd = c[1] && c[3] && c[5];
        ov = c[1] && c[4] && c[6];
        ecause = ov ? 3 : rd ? 2 : lo ? 1 : 0;
        if (irq !== (ecause != 0) || int'(irq_cause) != ecause) begin
          bad++;
          chk(1'b0, "irq merge R8", int'({irq, irq_cause}), ecause);
        end
      end
      chk(bad == 0, "irq sweep R8", bad, 0);
    end
    @(negedge clk);
    tx_enable = 0; ie_rxdata = 0; ie_rxovr = 0; rx_data_evt = 0; rx_ovr_evt = 0;
    ie_global = 1; ie_txlow = 1;

    // R7 and long R4: hold the engine busy, sweep fill levels and codes
    sample_div = 8'd255; carrier_div = 1; carrier_duty = 2;
    bytes_q[0] = 8'h00;
    load_bytes(1);
    hi_cnt = 0;
    @(negedge clk) tx_enable = 1'b1;
    @(negedge clk);
    for (int f = 0; f <= 32; f++) begin
      clear_q();
      for (int i = 0; i < f; i++) bytes_q[i] = 8'h81;
      if (f > 0) load_bytes(f);
      for (int s = 0; s < 4; s++) begin
        int exp_v;
        @(negedge clk) thr_sel = 2'(s);
        #5;
        exp_v = (f <= level_of(s)) ? 1 : 0;
        chk(irq == exp_v[0] && irq_cause == (exp_v[0] ? 2'b01 : 2'b00),
            "threshold R7", int'({irq, irq_cause}), exp_v);
      end
    end
    @(negedge clk) tx_enable = 1'b0;
    #5;
    chk(irq == 0, "tx disabled low R7", irq, 0);
    clear_q();
    for (int t = 0; t < 40000; t++) begin
      @(negedge clk);
      if (!ir_out) break;
    end
    chk(hi_cnt == 128 * 256, "long run R4 R3", hi_cnt, 128 * 256);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule